// File: doc/BRIEF.md
# Trigger-Gated Cascaded Clock Generator

This block runs on a kernel clock and derives two slower clocks from it through two integer dividers in series. The first divider produces a processing-clock enable, a one-cycle strobe once per processing period. The second divider counts those strobes and forms a bitstream clock level, which can be driven on either or both of two clock pads. Each pad also has a direction bit that sets its output enable.

Software controls the block through one 32-bit write port and one combinational readback word. Setting the run bit starts the dividers at once, or arms them so they wait for a chosen edge on one of several trigger inputs. While the generator is busy (armed, running or finishing its last period), the divider ratios, start mode, trigger select and trigger polarity are frozen. Clearing the run bit lets the current bitstream period end cleanly, and then the block returns to idle.

Top module: `trig_clkgen`

## Requirements
- R1: After reset, every readback bit, `proc_ce`, `cck_o` and `cck_oe` are 0.
- R2: While the busy flag (readback bit 31) is 0, `proc_ce` and `cck_o` stay 0, whatever the pad enable bits hold.
- R3: A write with bit 0 (run) set and bit 1 (start mode) clear, made while idle, makes the busy flag 1 in the next cycle. That cycle is cycle k=0 of the run.
- R4: With processing ratio field P (bits 14:8, 7 bits), `proc_ce` is high in run cycle k exactly when k mod (P+1) equals P. So P=0 gives a strobe every cycle, and 127 gives division by 128.
- R5: With bitstream ratio field B (bits 19:16), the bitstream level in run cycle k is high exactly when floor(k/(P+1)) mod (B+1) is below ceil((B+1)/2). This gives an equal split for even B+1 and one extra high processing period for odd B+1.
- R6: A start write with bit 1 set makes the block busy but idle at the outputs until a trigger event occurs. Clearing the run bit while still waiting makes the busy flag 0 two cycles after the write.
- R7: With polarity bit 2 at 0, only a rising edge of the selected trigger starts the run. With it at 1, only a falling edge does. An edge of the other polarity has no effect.
- R8: Trigger select field bits 7:4 with code c (2 or more) selects `trig_i[c-2]`. Codes 0 and 1 select nothing, and inputs that are not selected have no effect.
- R9: A trigger edge driven between clock edges is resynchronised over two flops. The first run cycle (k=0) begins after the third rising clock edge that follows the change.
- R10: `cck_o[i]` carries the bitstream level only while pad enable bit 20+i is 1. Otherwise it is 0.
- R11: `cck_oe[i]` follows direction bit 22+i (1 = output, 0 = input) from the cycle after the write, in any state.
- R12: While the busy flag is 1, writes leave bits 19:1 unchanged. The run, pad enable and direction bits stay writable.
- R13: Clearing the run bit while running keeps both outputs following R4 and R5 up to the end of the bitstream period that is in progress in the cycle after the write. In the cycle after that period ends, the busy flag, `proc_ce` and `cck_o` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Kernel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the control word |
| wr_data | input | 32 | Control word to write |
| rd_data | output | 32 | Control readback; bit 31 is the busy flag |
| trig_i | input | NTRIG | Asynchronous trigger inputs |
| proc_ce | output | 1 | Processing-clock enable strobe |
| cck_o | output | 2 | Bitstream clock level for each pad |
| cck_oe | output | 2 | Output enable for each pad |

## Verification
A processing counter that slips by even one state moves every later `proc_ce` strobe and every bitstream transition. The mismatch appears within one processing period and stays for the rest of the run. A bitstream counter that wraps at the wrong value changes the high/low pattern of `cck_o` within one bitstream period. A wrong idle, armed or running state shows up at the busy flag bit or as a missing or early first `cck_o` pulse, in the cycle of the trigger or stop. A lock that fails shows in the next readback.

// File: rtl/trig_clkgen.sv
module trig_clkgen #(
  parameter int NTRIG   = 14,
  parameter int PDW     = 7,
  parameter int BDW     = 4,
  parameter int SEL_OFS = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [31:0]      wr_data,
  output logic [31:0]      rd_data,
  input  logic [NTRIG-1:0] trig_i,
  output logic             proc_ce,
  output logic [1:0]       cck_o,
  output logic [1:0]       cck_oe
);

  localparam int RUN_B  = 0;
  localparam int MODE_B = 1;
  localparam int POL_B  = 2;
  localparam int SEL_L  = 4;
  localparam int PD_L   = 8;
  localparam int BD_L   = 16;
  localparam int PEN_L  = 20;
  localparam int DIR_L  = 22;
  localparam int BUSY_B = 31;

  typedef enum logic [1:0] {S_IDLE, S_ARMED, S_RUN} state_t;

  state_t           st;
  logic             cfg_run, cfg_mode, cfg_pol;
  logic [3:0]       cfg_sel;
  logic [PDW-1:0]   cfg_pdiv, pcnt;
  logic [BDW-1:0]   cfg_bdiv, bcnt;
  logic [1:0]       cfg_pen, cfg_dir;
  logic [NTRIG-1:0] sy1, sy2, sy3;
  logic             trg_now, trg_prev, trg_edge;
  logic             busy, running, bs_end, bs_hi;
  logic [BDW:0]     hi_len;
  logic             unused_wr;

  assign unused_wr = ^wr_data;
  assign busy      = (st != S_IDLE);
  assign running   = (st == S_RUN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_run  <= 1'b0;
      cfg_mode <= 1'b0;
      cfg_pol  <= 1'b0;
      cfg_sel  <= '0;
      cfg_pdiv <= '0;
      cfg_bdiv <= '0;
      cfg_pen  <= '0;
      cfg_dir  <= '0;
    end else if (wr_en) begin
      cfg_run <= wr_data[RUN_B];
      cfg_pen <= wr_data[PEN_L +: 2];
      cfg_dir <= wr_data[DIR_L +: 2];
      if (!busy) begin
        cfg_mode <= wr_data[MODE_B];
        cfg_pol  <= wr_data[POL_B];
        cfg_sel  <= wr_data[SEL_L +: 4];
        cfg_pdiv <= wr_data[PD_L +: PDW];
        cfg_bdiv <= wr_data[BD_L +: BDW];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sy1 <= '0;
      sy2 <= '0;
      sy3 <= '0;
    end else begin
      sy1 <= trig_i;
      sy2 <= sy1;
      sy3 <= sy2;
    end
  end

  always_comb begin
    trg_now  = 1'b0;
    trg_prev = 1'b0;
    for (int i = 0; i < NTRIG; i++) begin
      if (32'(cfg_sel) == i + SEL_OFS) begin
        trg_now  = sy2[i];
        trg_prev = sy3[i];
      end
    end
  end

  assign trg_edge = cfg_pol ? (trg_prev & ~trg_now) : (trg_now & ~trg_prev);

  assign proc_ce = running && (pcnt == cfg_pdiv);
  assign bs_end  = proc_ce && (bcnt == cfg_bdiv);
  assign hi_len  = ({1'b0, cfg_bdiv} + (BDW+1)'(2)) >> 1;
  assign bs_hi   = ({1'b0, bcnt} < hi_len);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
    end else begin
      case (st)
        S_IDLE:
          if (wr_en && wr_data[RUN_B])
            st <= wr_data[MODE_B] ? S_ARMED : S_RUN;
        S_ARMED:
          if (!cfg_run)      st <= S_IDLE;
          else if (trg_edge) st <= S_RUN;
        S_RUN:
          if (!cfg_run && bs_end) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pcnt <= '0;
      bcnt <= '0;
    end else if (!running) begin
      pcnt <= '0;
      bcnt <= '0;
    end else begin
      pcnt <= proc_ce ? '0 : pcnt + 1'b1;
      if (proc_ce)
        bcnt <= bs_end ? '0 : bcnt + 1'b1;
    end
  end

  assign cck_o  = {2{running & bs_hi}} & cfg_pen;
  assign cck_oe = cfg_dir;

  always_comb begin
    rd_data              = '0;
    rd_data[RUN_B]       = cfg_run;
    rd_data[MODE_B]      = cfg_mode;
    rd_data[POL_B]       = cfg_pol;
    rd_data[SEL_L +: 4]  = cfg_sel;
    rd_data[PD_L +: PDW] = cfg_pdiv;
    rd_data[BD_L +: BDW] = cfg_bdiv;
    rd_data[PEN_L +: 2]  = cfg_pen;
    rd_data[DIR_L +: 2]  = cfg_dir;
    rd_data[BUSY_B]      = busy;
  end

endmodule

// File: rtl/trig_clkgen_chk.sv
module trig_clkgen_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic        wr_go,
  input logic        wr_mode,
  input logic        busy,
  input logic [18:0] prot,
  input logic        pdiv_nz,
  input logic [1:0]  pen,
  input logic        proc_ce,
  input logic [1:0]  cck_o
);

  // R2
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!proc_ce && cck_o == 2'b00));

  // R3
  direct_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && wr_en && wr_go && !wr_mode) |=> busy);

  // R4
  strobe_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (proc_ce && pdiv_nz) |=> !proc_ce);

  // R10
  pad0_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pen[0] |-> !cck_o[0]);

  // R10
  pad1_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pen[1] |-> !cck_o[1]);

  // R12
  cfg_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && wr_en) |=> (prot == $past(prot)));

endmodule

bind trig_clkgen trig_clkgen_chk u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .wr_en   (wr_en),
  .wr_go   (wr_data[0]),
  .wr_mode (wr_data[1]),
  .busy    (rd_data[31]),
  .prot    (rd_data[19:1]),
  .pdiv_nz (|rd_data[8 +: PDW]),
  .pen     (rd_data[21:20]),
  .proc_ce (proc_ce),
  .cck_o   (cck_o)
);

// File: tb/trig_clkgen_test.sv
module trig_clkgen_test;

  localparam int NTRIG = 14;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             wr_en = 1'b0;
  logic [31:0]      wr_data = '0;
  logic [31:0]      rd_data;
  logic [NTRIG-1:0] trig_i = '0;
  logic             proc_ce;
  logic [1:0]       cck_o, cck_oe;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  trig_clkgen uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .trig_i(trig_i), .proc_ce(proc_ce),
    .cck_o(cck_o), .cck_oe(cck_oe)
  );

  task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic wr(logic [31:0] d);
    wr_en = 1'b1;
    wr_data = d;
    tick();
    wr_en = 1'b0;
  endtask

  function automatic logic exp_hi(int k, int p, int b);
    return ((k / (p + 1)) % (b + 1)) < ((b + 2) / 2);
  endfunction

  function automatic logic [31:0] word(bit run, bit mode, bit pol, int sel,
                                       int p, int b, logic [1:0] pen, logic [1:0] dir);
    return {8'h00, dir, pen, 4'(b), 1'b0, 7'(p), 4'(sel), 1'b0, pol, mode, run};
  endfunction

  // Called at the negedge of run cycle k=0.
  task automatic run_seq(int p, int b, logic [1:0] pen, logic [1:0] dir,
                         int lock_at, int stop_at, logic [31:0] base);
    int t = (p + 1) * (b + 1);
    int m = stop_at + 1;
    int jend = (m / t) * t + t - 1;
    for (int k = 0; k <= jend + 1; k++) begin
      if (k <= jend) begin
        check(rd_data[31] == 1'b1, "R13 busy while finishing", rd_data[31], 1);
        check(proc_ce == (k % (p + 1) == p), "R4 proc strobe", proc_ce, (k % (p + 1) == p));
        check(cck_o == (pen & {2{exp_hi(k, p, b)}}), "R5 R10 bitstream level",
              cck_o, pen & {2{exp_hi(k, p, b)}});
      end else begin
        check(rd_data[31] == 1'b0 && cck_o == 2'b00 && !proc_ce, "R13 stopped after period",
              {rd_data[31], cck_o, proc_ce}, 0);
      end
      if (k == lock_at) begin
        wr_en = 1'b1;
        wr_data = base ^ 32'h000A_5596;
      end else if (k == stop_at) begin
        wr_en = 1'b1;
        wr_data = word(0, 0, 0, 0, 0, 0, pen, dir);
      end else begin
        wr_en = 1'b0;
      end
      tick();
    end
    wr_en = 1'b0;
    if (lock_at >= 0)
      check(rd_data[19:1] == base[19:1], "R12 protected fields kept", rd_data[19:1], base[19:1]);
  endtask

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd2741));
    tick();
    tick();
    check(rd_data == 0 && cck_o == 0 && cck_oe == 0 && !proc_ce, "R1 reset state",
          {rd_data[30:0], proc_ce}, 0);
    rst_n = 1'b1;
    tick();

    // R2: pads enabled, run clear
    wr(word(0, 0, 0, 0, 3, 2, 2'b11, 2'b11));
    for (int i = 0; i < 20; i++) begin
      check(!proc_ce && cck_o == 0 && !rd_data[31], "R2 idle quiet", {proc_ce, cck_o}, 0);
      tick();
    end
    // R11
    check(cck_oe == 2'b11, "R11 direction while idle", cck_oe, 2'b11);

    // directed corners then random ones, direct start mode
    for (int n = 0; n < 16; n++) begin
      int p, b;
      logic [1:0] pen, dir;
      logic [31:0] base;
      p = (n == 0) ? 0 : (n == 1) ? 127 : (n == 2) ? 0 : int'($urandom % 8);
      b = (n == 0) ? 0 : (n == 1) ? 1 : (n == 2) ? 15 : int'($urandom % 16);
      pen = (n < 3) ? 2'b11 : 2'($urandom);
      dir = 2'($urandom);
      base = word(1, 0, 0, 0, p, b, pen, dir);
      wr(base);
      // R3
      check(rd_data[31] == 1'b1, "R3 busy after start", rd_data[31], 1);
      check(cck_oe == dir, "R11 pad direction", cck_oe, dir);
      run_seq(p, b, pen, dir, 2, 3 + int'($urandom % ((p + 1) * (b + 1) + 4)), base);
    end

    // triggered start
    for (int n = 0; n < 8; n++) begin
      int p, b, sel, idx;
      bit pol;
      logic [31:0] base;
      p = int'($urandom % 4);
      b = int'($urandom % 6);
      sel = 2 + int'($urandom % 14);
      idx = sel - 2;
      pol = (n < 2) ? 1'(n) : 1'($urandom);
      trig_i = '0;
      trig_i[idx] = ~pol;
      repeat (4) tick();
      base = word(1, 1, pol, sel, p, b, 2'b11, 2'b00);
      wr(base);
      check(rd_data[31] == 1'b1 && cck_o == 0 && !proc_ce, "R6 armed and waiting",
            {rd_data[31], cck_o, proc_ce}, 32'h8);
      trig_i = trig_i ^ ~(NTRIG'(1) << idx);
      repeat (5) begin
        tick();
        check(cck_o == 0 && !proc_ce, "R8 other inputs ignored", {cck_o, proc_ce}, 0);
      end
      trig_i[idx] = pol;
      repeat (5) begin
        tick();
        check(cck_o == 0 && !proc_ce, "R7 wrong polarity ignored", {cck_o, proc_ce}, 0);
      end
      trig_i[idx] = ~pol;
      tick();
      tick();
      check(cck_o == 0, "R9 not started before third edge", cck_o, 0);
      tick();
      check(cck_o == 2'b11, "R9 started on third edge", cck_o, 2'b11);
      run_seq(p, b, 2'b11, 2'b00, -1, 4 + int'($urandom % 10), base);
    end

    // R8: code 1 selects nothing
    trig_i = '0;
    wr(word(1, 1, 0, 1, 0, 0, 2'b11, 2'b00));
    for (int i = 0; i < 3; i++) begin
      trig_i = ~trig_i;
      repeat (5) begin
        tick();
        check(rd_data[31] && cck_o == 0 && !proc_ce, "R8 code 1 never starts",
              {rd_data[31], cck_o, proc_ce}, 32'h8);
      end
    end
    // R6: abort while armed
    wr(word(0, 0, 0, 0, 0, 0, 2'b11, 2'b00));
    check(rd_data[31] == 1'b1, "R6 still busy one cycle after abort", rd_data[31], 1);
    tick();
    check(rd_data[31] == 1'b0, "R6 idle two cycles after abort", rd_data[31], 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule